// File: doc/BRIEF.md
# Burst column address sequencer

This block sits in a DRAM command path and turns one column command into the list of column addresses of a burst. A mode-register write configures it. That write carries a 13-bit value and a 2-bit bank select. The block takes three things from the write: the burst length (2, 4 or 8), the ordering of beats (linear or interleaved), and the read latency code. It decodes the latency code into half-clock units for the read-data path.

When a burst start arrives with a 10-bit column, the block presents the first column on the next cycle. It then steps to the next beat each time the consumer asserts the advance input. Beats wrap inside an aligned block whose size is the burst length, so the column bits above that block never change during a burst. A new start in the middle of a burst cuts the burst short and restarts from the new column.

After a mode-register write, burst starts are refused for a short guard window. A write that carries a reserved code is rejected: an error flag is raised and the previous settings are kept.

Top module: `brst_colseq`

## Requirements
- R1: After synchronous reset, `beat_vld`, `beat_last` and `mr_err` are 0, `lat_x2` is 4, and the burst setting is length 2 in sequential order.
- R2: A mode write (`mr_wr`=1) is taken only when `mr_bank` is 00. With any other bank value it changes neither the settings nor `mr_err`.
- R3: Bits 2:0 of `mr_val` set the burst length: 001 gives 2, 010 gives 4, 011 gives 8.
- R4: Bit 3 of `mr_val` selects the order: 0 is sequential, 1 is interleaved.
- R5: Bits 6:4 of `mr_val` set the latency: 010 makes `lat_x2`=4 and 110 makes `lat_x2`=5. `lat_x2` only ever holds 4 or 5.
- R6: A taken mode write whose length code or latency code is reserved sets `mr_err`=1 and leaves every setting, including the order bit, unchanged. A taken write with valid codes applies all three fields and clears `mr_err`.
- R7: In sequential order with length BL and start column S, beat i has low bits equal to (S mod BL + i) mod BL, the remaining bits of S unchanged.
- R8: In interleaved order, beat i has column S XOR i.
- R9: `beat_vld` rises in the cycle after an accepted start, with `col_out` equal to the start column. The beat advances by one only in the cycle after `beat_adv`=1, and otherwise holds. `beat_last` is 1 exactly on beat BL-1. Advancing from that beat drops `beat_vld`.
- R10: A start accepted while a burst is running ends that burst. The next cycle shows beat 0 of the new column, and a start takes priority over an advance in the same cycle.
- R11: A start in the same cycle as a taken mode write, or in either of the two cycles after it, is ignored.
- R12: The burst length and order used by a burst are those in force when it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_wr | input | 1 | Mode-register write strobe |
| mr_bank | input | 2 | Bank select of the mode write; must be 00 to take effect |
| mr_val | input | 13 | Mode value: length [2:0], order [3], latency [6:4] |
| bst_go | input | 1 | Burst start strobe |
| bst_col | input | 10 | Starting column of the burst |
| beat_adv | input | 1 | Consume the current beat and step to the next |
| col_out | output | 10 | Column of the current beat |
| beat_vld | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one of the burst |
| lat_x2 | output | 3 | Read latency in half clocks (4 or 5) |
| mr_err | output | 1 | Last taken mode write carried a reserved code |

## Verification
Each of the three lengths is combined with both orders, and bursts start at every one of the eight low-bit column offsets. Upper column bits vary between runs. Taken together, this separates correct wrapping from a plain counter and tells the two orders apart, since the two sequences coincide only at some offsets.

Half the bursts insert idle cycles between advances, which shows that the beat holds rather than free-running. Directed cases cover several behaviours:
- a mid-burst restart, with an advance in the same cycle as the start;
- starts inside the guard window;
- rejected writes, whose kept length is made visible by the length of the next burst;
- writes to a non-zero bank, whose settings must not take effect.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // mode value field positions (decoded by the configuration stage)
    localparam int BL_LSB = 0;
    localparam int BT_BIT = 3;
    localparam int CL_LSB = 4;
    localparam int CODE_W = 3;

    // widest burst is 8 beats: 3 offset bits
    localparam int OFS_W  = 3;
    localparam int LOG_W  = 2;

    typedef struct packed {
        logic [LOG_W-1:0] bl_log;  // log2 of burst length (1..3)
        logic             intlv;   // 1: interleaved order
        logic [2:0]       lat_x2;  // latency in half clocks
    } mode_cfg_t;

    localparam mode_cfg_t RST_CFG = '{bl_log: 2'd1, intlv: 1'b0, lat_x2: 3'd4};

    typedef struct packed {
        logic             ok;
        logic [LOG_W-1:0] lg;
    } bl_dec_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] hx2;
    } cl_dec_t;

    function automatic bl_dec_t dec_len(input logic [CODE_W-1:0] code);
        bl_dec_t r;
        r.ok = 1'b1;
        unique case (code)
            3'b001:  r.lg = 2'd1;
            3'b010:  r.lg = 2'd2;
            3'b011:  r.lg = 2'd3;
            default: begin r.ok = 1'b0; r.lg = 2'd1; end
        endcase
        return r;
    endfunction

    function automatic cl_dec_t dec_lat(input logic [CODE_W-1:0] code);
        cl_dec_t r;
        r.ok = 1'b1;
        unique case (code)
            3'b010:  r.hx2 = 3'd4;
            3'b110:  r.hx2 = 3'd5;
            default: begin r.ok = 1'b0; r.hx2 = 3'd4; end
        endcase
        return r;
    endfunction

    function automatic logic [OFS_W-1:0] len_mask(input logic [LOG_W-1:0] lg);
        return OFS_W'((4'd1 << lg) - 4'd1);
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int MR_W  = 13,
    parameter int BA_W  = 2,
    parameter int GUARD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [BA_W-1:0] wr_bank,
    input  logic [MR_W-1:0] wr_val,
    output mode_cfg_t       cfg,
    output logic            err,
    output logic            busy
);
    localparam int GRD_W = $clog2(GUARD + 1);

    logic             hit;
    bl_dec_t          bl_d;
    cl_dec_t          cl_d;
    logic [GRD_W-1:0] grd_q;
    logic             unused_hi;

    assign hit       = wr_en && (wr_bank == '0);
    assign bl_d      = dec_len(wr_val[BL_LSB +: CODE_W]);
    assign cl_d      = dec_lat(wr_val[CL_LSB +: CODE_W]);
    assign unused_hi = ^wr_val[MR_W-1:CL_LSB+CODE_W];
    assign busy      = hit || (grd_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= RST_CFG;
            err   <= 1'b0;
            grd_q <= '0;
        end else begin
            if (grd_q != '0)
                grd_q <= grd_q - 1'b1;
            if (hit) begin
                grd_q <= GRD_W'(GUARD);
                if (bl_d.ok && cl_d.ok) begin
                    cfg.bl_log <= bl_d.lg;
                    cfg.intlv  <= wr_val[BT_BIT];
                    cfg.lat_x2 <= cl_d.hx2;
                    err        <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [COL_W-1:0] go_col,
    input  logic             adv,
    input  mode_cfg_t        cfg,
    output logic [COL_W-1:0] col,
    output logic             vld,
    output logic             last
);
    logic [COL_W-1:0] base_q;
    logic [OFS_W-1:0] idx_q;
    logic [LOG_W-1:0] lg_q;
    logic             ilv_q;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] s_lo;
    logic [OFS_W-1:0] seq_lo;
    logic [OFS_W-1:0] ilv_lo;
    logic [OFS_W-1:0] new_lo;

    assign mask   = len_mask(lg_q);
    assign s_lo   = base_q[OFS_W-1:0];
    assign seq_lo = s_lo + idx_q;
    assign ilv_lo = s_lo ^ idx_q;
    assign last   = vld && (idx_q == mask);

    // bits inside the burst block follow the order, bits outside keep the start
    for (genvar g = 0; g < OFS_W; g++) begin : g_lo
        assign new_lo[g] = mask[g] ? (ilv_q ? ilv_lo[g] : seq_lo[g]) : s_lo[g];
    end

    assign col = {base_q[COL_W-1:OFS_W], new_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx_q  <= '0;
            lg_q   <= RST_CFG.bl_log;
            ilv_q  <= 1'b0;
            vld    <= 1'b0;
        end else if (go) begin
            base_q <= go_col;
            idx_q  <= '0;
            lg_q   <= cfg.bl_log;
            ilv_q  <= cfg.intlv;
            vld    <= 1'b1;
        end else if (vld && adv) begin
            if (idx_q == mask)
                vld <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/brst_colseq.sv
module brst_colseq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int MR_W  = 13,
    parameter int BA_W  = 2,
    parameter int GUARD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_wr,
    input  logic [BA_W-1:0]  mr_bank,
    input  logic [MR_W-1:0]  mr_val,
    input  logic             bst_go,
    input  logic [COL_W-1:0] bst_col,
    input  logic             beat_adv,
    output logic [COL_W-1:0] col_out,
    output logic             beat_vld,
    output logic             beat_last,
    output logic [2:0]       lat_x2,
    output logic             mr_err
);
    mode_cfg_t cfg;
    logic      busy;
    logic      go_ok;

    bcs_mode_reg #(.MR_W(MR_W), .BA_W(BA_W), .GUARD(GUARD)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mr_wr),
        .wr_bank (mr_bank),
        .wr_val  (mr_val),
        .cfg     (cfg),
        .err     (mr_err),
        .busy    (busy)
    );

    assign go_ok  = bst_go && !busy;
    assign lat_x2 = cfg.lat_x2;

    bcs_beat_gen #(.COL_W(COL_W)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .go     (go_ok),
        .go_col (bst_col),
        .adv    (beat_adv),
        .cfg    (cfg),
        .col    (col_out),
        .vld    (beat_vld),
        .last   (beat_last)
    );

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int COL_W = 10,
    parameter int BA_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mr_wr,
    input logic [BA_W-1:0]  mr_bank,
    input logic             bst_go,
    input logic [COL_W-1:0] bst_col,
    input logic             beat_adv,
    input logic [COL_W-1:0] col_out,
    input logic             beat_vld,
    input logic             beat_last,
    input logic [2:0]       lat_x2,
    input logic             mr_err
);
    logic       mw;
    logic [1:0] since;

    assign mw = mr_wr && (mr_bank == '0);

    always_ff @(posedge clk) begin
        if (rst)
            since <= 2'd3;
        else if (mw)
            since <= 2'd0;
        else if (since != 2'd3)
            since <= since + 2'd1;
    end

    assert_last_in_burst_R9: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_vld);

    assert_hold_no_adv_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !beat_adv && !bst_go) |=> (beat_vld && $stable(col_out)));

    assert_end_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_last && beat_adv && !bst_go) |=> !beat_vld);

    assert_guard_block_R11: assert property (@(posedge clk) disable iff (rst)
        (bst_go && !beat_vld && (mw || since < 2'd2)) |=> !beat_vld);

    assert_restart_col_R10: assert property (@(posedge clk) disable iff (rst)
        (bst_go && !mw && since >= 2'd2) |=> (beat_vld && col_out == $past(bst_col)));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && beat_adv && !bst_go) |=>
        (!beat_vld || col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

    assert_lat_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (lat_x2 == 3'd4) || (lat_x2 == 3'd5));

    assert_err_keeps_lat_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mr_err) |-> $stable(lat_x2));

endmodule

bind brst_colseq bcs_chk #(.COL_W(COL_W), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mr_wr     (mr_wr),
    .mr_bank   (mr_bank),
    .bst_go    (bst_go),
    .bst_col   (bst_col),
    .beat_adv  (beat_adv),
    .col_out   (col_out),
    .beat_vld  (beat_vld),
    .beat_last (beat_last),
    .lat_x2    (lat_x2),
    .mr_err    (mr_err)
);

// File: tb/brst_colseq_tb.sv
`timescale 1ns/1ps
module brst_colseq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mr_wr = 1'b0;
    logic [1:0]  mr_bank = '0;
    logic [12:0] mr_val = '0;
    logic        bst_go = 1'b0;
    logic [9:0]  bst_col = '0;
    logic        beat_adv = 1'b0;
    logic [9:0]  col_out;
    logic        beat_vld;
    logic        beat_last;
    logic [2:0]  lat_x2;
    logic        mr_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    brst_colseq u_dut (
        .clk(clk), .rst(rst), .mr_wr(mr_wr), .mr_bank(mr_bank), .mr_val(mr_val),
        .bst_go(bst_go), .bst_col(bst_col), .beat_adv(beat_adv),
        .col_out(col_out), .beat_vld(beat_vld), .beat_last(beat_last),
        .lat_x2(lat_x2), .mr_err(mr_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mval(input int blc, input int ty, input int clc);
        return (clc << 4) | (ty << 3) | blc;
    endfunction

    function automatic int exp_col(input int col, input int bl, input int ty, input int i);
        int s  = col & 7;
        int m  = bl - 1;
        int lo = ty ? (s ^ i) : ((s & ~m) | ((s + i) & m));
        return (col & ~7) | lo;
    endfunction

    // mode write, then wait out the guard window
    task automatic mode_wr(input int ba, input int v);
        mr_wr = 1'b1; mr_bank = 2'(ba); mr_val = 13'(v);
        tick();
        mr_wr = 1'b0; mr_bank = '0;
        tick();
        tick();
    endtask

    // full burst with beat-by-beat checks; gaps inserts idle cycles
    task automatic run_burst(input int col, input int bl, input int ty, input bit gaps, input string req);
        bst_go = 1'b1; bst_col = 10'(col); beat_adv = 1'b0;
        tick();
        bst_go = 1'b0;
        for (int i = 0; i < bl; i++) begin
            chk(beat_vld == 1'b1, {req, " R9 vld"}, beat_vld, 1);
            chk(col_out == 10'(exp_col(col, bl, ty, i)), {req, " col"}, col_out, exp_col(col, bl, ty, i));
            chk(beat_last == (i == bl - 1), "R9 last", beat_last, (i == bl - 1));
            if (gaps) begin
                beat_adv = 1'b0;
                tick();
                chk(col_out == 10'(exp_col(col, bl, ty, i)), "R9 hold", col_out, exp_col(col, bl, ty, i));
            end
            beat_adv = 1'b1;
            tick();
        end
        beat_adv = 1'b0;
        chk(beat_vld == 1'b0, "R9 end", beat_vld, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ts;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk(beat_vld == 1'b0, "R1 vld", beat_vld, 0);
        chk(beat_last == 1'b0, "R1 last", beat_last, 0);
        chk(lat_x2 == 3'd4, "R1 lat", lat_x2, 4);
        chk(mr_err == 1'b0, "R1 err", mr_err, 0);
        run_burst(10'h2D7, 2, 0, 1'b0, "R1 default");

        // R3 R4 R7 R8: every length, both orders, every start offset
        for (int blc = 1; blc <= 3; blc++) begin
            for (int ty = 0; ty < 2; ty++) begin
                mode_wr(0, mval(blc, ty, 2));
                for (int s = 0; s < 8; s++) begin
                    int col = (s | ((blc * 37 + ty * 11 + s * 13) << 3)) & 1023;
                    run_burst(col, 1 << blc, ty, s[0], ty ? "R8 R4 R3" : "R7 R4 R3");
                end
            end
        end

        // R5 latency codes
        mode_wr(0, mval(3, 0, 6));
        chk(lat_x2 == 3'd5, "R5 cl2.5", lat_x2, 5);
        chk(mr_err == 1'b0, "R6 valid clears", mr_err, 0);
        mode_wr(0, mval(3, 0, 2));
        chk(lat_x2 == 3'd4, "R5 cl2", lat_x2, 4);

        // R2 non-zero bank is ignored
        mode_wr(1, mval(1, 1, 6));
        chk(lat_x2 == 3'd4, "R2 lat kept", lat_x2, 4);
        chk(mr_err == 1'b0, "R2 err kept", mr_err, 0);
        run_burst(10'h0A5, 8, 0, 1'b0, "R2 len kept");
        mode_wr(3, mval(7, 0, 1));
        chk(mr_err == 1'b0, "R2 bad code other bank", mr_err, 0);

        // R6 reserved length code, then reserved latency code
        mode_wr(0, mval(7, 1, 6));
        chk(mr_err == 1'b1, "R6 err on bad len", mr_err, 1);
        chk(lat_x2 == 3'd4, "R6 lat kept", lat_x2, 4);
        run_burst(10'h133, 8, 0, 1'b0, "R6 len/order kept");
        mode_wr(0, mval(1, 1, 3));
        chk(mr_err == 1'b1, "R6 err on bad lat", mr_err, 1);
        run_burst(10'h0F1, 8, 0, 1'b0, "R6 len kept2");
        mode_wr(0, mval(2, 1, 6));
        chk(mr_err == 1'b0, "R6 cleared", mr_err, 0);
        chk(lat_x2 == 3'd5, "R6 applied lat", lat_x2, 5);
        run_burst(10'h016, 4, 1, 1'b0, "R6 applied");

        // R10 truncation: BL8 seq, restart mid-burst with adv also high
        mode_wr(0, mval(3, 0, 2));
        bst_go = 1'b1; bst_col = 10'h105; tick(); bst_go = 1'b0;
        beat_adv = 1'b1; tick(); tick();
        chk(col_out == 10'h107, "R10 pre", col_out, 10'h107);
        bst_go = 1'b1; bst_col = 10'h2A3; tick(); bst_go = 1'b0; beat_adv = 1'b0;
        chk(beat_vld == 1'b1, "R10 vld", beat_vld, 1);
        chk(col_out == 10'h2A3, "R10 restart col", col_out, 10'h2A3);
        chk(beat_last == 1'b0, "R10 not last", beat_last, 0);
        for (int i = 1; i < 8; i++) begin
            beat_adv = 1'b1; tick();
            chk(col_out == 10'(exp_col(10'h2A3, 8, 0, i)), "R10 walk", col_out, exp_col(10'h2A3, 8, 0, i));
        end
        chk(beat_last == 1'b1, "R10 last", beat_last, 1);
        tick(); beat_adv = 1'b0;
        chk(beat_vld == 1'b0, "R10 end", beat_vld, 0);

        // R12 config snapshot: change to BL2 during a BL8 burst
        bst_go = 1'b1; bst_col = 10'h040; tick(); bst_go = 1'b0;
        mr_wr = 1'b1; mr_val = 13'(mval(1, 1, 2)); tick(); mr_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk(col_out == 10'(exp_col(10'h040, 8, 0, i)), "R12 col", col_out, exp_col(10'h040, 8, 0, i));
            beat_adv = 1'b1; tick();
        end
        beat_adv = 1'b0;
        chk(beat_vld == 1'b0, "R12 end", beat_vld, 0);

        // R11 guard window: start held from the mode write cycle onward
        mr_wr = 1'b1; mr_val = 13'(mval(2, 0, 2)); bst_go = 1'b1; bst_col = 10'h1F6;
        tick();
        mr_wr = 1'b0;
        chk(beat_vld == 1'b0, "R11 same cycle", beat_vld, 0);
        tick();
        chk(beat_vld == 1'b0, "R11 +1", beat_vld, 0);
        tick();
        chk(beat_vld == 1'b0, "R11 +2", beat_vld, 0);
        tick();
        bst_go = 1'b0;
        chk(beat_vld == 1'b1, "R11 +3 accepted", beat_vld, 1);
        chk(col_out == 10'h1F6, "R11 col", col_out, 10'h1F6);
        ts = 0;
        while (beat_vld && ts < 20) begin
            beat_adv = 1'b1; tick(); ts++;
        end
        beat_adv = 1'b0;
        chk(ts == 4, "R11 len4", ts, 4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule